// File: doc/BRIEF.md
# Processor Clock Throttling Controller

This block holds one 32-bit control word and drives a stop-clock request that slows the processor by a programmed duty cycle. Software writes the word through a plain write strobe and reads it back in the same cycle. Two enables can start throttling. One is an ordinary throttle enable that uses its own duty field. The other is a forced thermal throttle that uses a separate thermal duty field. When both are set, the forced path wins.

Time is split into slots by an external slot tick, and eight slots form one window. A duty value N asks for the clock to be stopped in N of the eight slots. The stop output moves only on a slot tick, so no slot is ever cut short. The thermal duty field can be written only once: the first write after reset sets it and locks it, and only reset clears that lock. A read-only status bit shows whether throttling is in effect.

Top module: `thr_clk_throttle`

## Requirements
- R1: Reset is synchronous and active high. During reset and in the cycle after it, `rd_data` reads 0 and `stop_clk` is 0.
- R2: Bits [3:1] (normal duty), bit 4 (throttle enable) and bit 8 (force thermal throttle) are written by every write and read back unchanged. All bits other than [8:1] and 16 always read 0.
- R3: Bits [7:5] (thermal duty) take the value from the first write after reset. Every later write leaves them unchanged.
- R4: Bit 16 is read-only. It reads 1 when the selected duty is nonzero and either bit 8 or bit 4 is set, and 0 otherwise. Writes to it have no effect.
- R5: Once throttling starts from idle, the k-th slot tick (k counted from 0) sets `stop_clk` to 1 when (k mod 8) is less than the selected duty, and to 0 otherwise.
- R6: `stop_clk` changes only in the cycle that follows a cycle in which `slot_tick` was high.
- R7: When bit 8 is set, the selected duty is the thermal duty [7:5], even if bit 4 is also set. Otherwise it is the normal duty [3:1].
- R8: A selected duty of 0 means no throttling: status reads 0 and `stop_clk` stays 0 across slot ticks.
- R9: The write-once lock on bits [7:5] is cleared only by reset. The first write after a new reset again sets the thermal duty.
- R10: When throttling stops, the next slot tick drives `stop_clk` to 0. A later restart begins a fresh window at k = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Data to write |
| rd_data | output | 32 | Current control word, including the status bit |
| slot_tick | input | 1 | One-cycle pulse that marks a slot boundary |
| stop_clk | output | 1 | Request to stop the processor clock for the current slot |

## Verification
The hardest case to reach is the write-once field after a reset, because the very first write of each test decides the thermal duty for the rest of that test. Each scenario therefore begins with its own reset and picks its first write on purpose. Some scenarios lock a nonzero thermal duty, and others lock zero and then try to overwrite it. Priority is checked by running a full forced window and then, with the window counter back at zero, dropping the force bit so that the normal duty takes over from slot 0.

// File: rtl/thr_pkg.sv
package thr_pkg;
    localparam int DUTY_W   = 3;
    localparam int REG_W    = 32;
    localparam int NDUTY_LO = 1;
    localparam int EN_BIT   = 4;
    localparam int TDUTY_LO = 5;
    localparam int FORCE_BIT = 8;
    localparam int STAT_BIT = 16;

    typedef logic [DUTY_W-1:0] duty_t;

    typedef struct packed {
        duty_t thermal_duty;
        logic  force_on;
        logic  thr_en;
        duty_t norm_duty;
    } ctrl_t;

    function automatic duty_t pick_duty(ctrl_t c);
        if (c.force_on)
            return c.thermal_duty;
        else if (c.thr_en)
            return c.norm_duty;
        else
            return '0;
    endfunction

    function automatic logic [REG_W-1:0] pack_word(ctrl_t c, logic active);
        logic [REG_W-1:0] w;
        w = '0;
        w[NDUTY_LO +: DUTY_W] = c.norm_duty;
        w[EN_BIT]             = c.thr_en;
        w[TDUTY_LO +: DUTY_W] = c.thermal_duty;
        w[FORCE_BIT]          = c.force_on;
        w[STAT_BIT]           = active;
        return w;
    endfunction
endpackage

// File: rtl/thr_ctrl_reg.sv
module thr_ctrl_reg
    import thr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output ctrl_t            ctrl
);
    duty_t norm_q, therm_q;
    logic  en_q, force_q, locked_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            norm_q   <= '0;
            therm_q  <= '0;
            en_q     <= 1'b0;
            force_q  <= 1'b0;
            locked_q <= 1'b0;
        end else if (wr_en) begin
            norm_q   <= wr_data[NDUTY_LO +: DUTY_W];
            en_q     <= wr_data[EN_BIT];
            force_q  <= wr_data[FORCE_BIT];
            locked_q <= 1'b1;
            if (!locked_q)
                therm_q <= wr_data[TDUTY_LO +: DUTY_W];
        end
    end

    always_comb begin
        ctrl.norm_duty    = norm_q;
        ctrl.thr_en       = en_q;
        ctrl.thermal_duty = therm_q;
        ctrl.force_on     = force_q;
    end

    // R3
    thermal_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (locked_q && wr_en) |=> $stable(therm_q));
endmodule

// File: rtl/thr_duty_engine.sv
module thr_duty_engine
    import thr_pkg::*;
#(
    parameter int DW = DUTY_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          slot_tick,
    input  logic [DW-1:0] duty,
    output logic          stop_clk
);
    localparam int SLOTS = 2 ** DW;

    logic [DW-1:0] slot_q;
    logic          active;

    assign active = (duty != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q   <= '0;
            stop_clk <= 1'b0;
        end else if (!active) begin
            slot_q <= '0;
            if (slot_tick)
                stop_clk <= 1'b0;
        end else if (slot_tick) begin
            stop_clk <= (slot_q < duty);
            slot_q   <= (32'(slot_q) == SLOTS - 1) ? '0 : slot_q + 1'b1;
        end
    end

    // R6
    stop_on_slot_chk: assert property (@(posedge clk) disable iff (rst)
        !slot_tick |=> $stable(stop_clk));

    // R8
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        (!active && slot_tick) |=> !stop_clk);

    // R1
    reset_stop_chk: assert property (@(posedge clk)
        rst |=> !stop_clk);
endmodule

// File: rtl/thr_clk_throttle.sv
module thr_clk_throttle
    import thr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic        slot_tick,
    output logic        stop_clk
);
    ctrl_t ctrl;
    duty_t sel_duty;
    logic  thr_active;

    thr_ctrl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl    (ctrl)
    );

    assign sel_duty   = pick_duty(ctrl);
    assign thr_active = (sel_duty != '0);
    assign rd_data    = pack_word(ctrl, thr_active);

    thr_duty_engine #(.DW(DUTY_W)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .slot_tick (slot_tick),
        .duty      (sel_duty),
        .stop_clk  (stop_clk)
    );

    // R4
    status_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_data[STAT_BIT] && !rd_data[FORCE_BIT] && !rd_data[EN_BIT] && slot_tick) |=> !stop_clk);
endmodule

// File: tb/thr_clk_throttle_bench.sv
module thr_clk_throttle_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        slot_tick = 1'b0;
    logic        stop_clk;

    int n_chk = 0;
    int n_bad = 0;

    thr_clk_throttle u_thr_clk_throttle (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .slot_tick (slot_tick),
        .stop_clk  (stop_clk)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] word(int nd, bit en, int td, bit frc);
        return 32'((nd & 7) << 1) | (32'(en) << 4) | 32'((td & 7) << 5) | (32'(frc) << 8);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; slot_tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic tick_exp(string req, bit exp);
        slot_tick = 1'b1;
        @(negedge clk);
        slot_tick = 1'b0;
        chk(req, 32'(stop_clk), 32'(exp));
        @(negedge clk);
        chk({req, " R6 hold"}, 32'(stop_clk), 32'(exp));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        @(negedge clk);
        chk("R1 rd in reset", rd_data, 32'h0);
        chk("R1 stop in reset", 32'(stop_clk), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rd after reset", rd_data, 32'h0);
        chk("R1 stop after reset", 32'(stop_clk), 32'h0);
    endtask

    task automatic t_readback();
        do_reset();
        wr(32'hFFFF_FFFF);
        chk("R2 R4 all-ones readback", rd_data, 32'h0001_01FE);
        wr(32'h0);
        chk("R3 thermal kept after clear", rd_data, 32'h0000_00E0);
        wr(32'h0001_0000);
        chk("R4 status write ignored", rd_data, 32'h0000_00E0);
    endtask

    task automatic t_normal_window();
        do_reset();
        wr(word(3, 1, 0, 0));
        chk("R4 status on", rd_data[16], 1'b1);
        for (int k = 0; k < 16; k++)
            tick_exp($sformatf("R5 normal slot %0d", k), (k % 8) < 3);
        wr(word(0, 0, 5, 1));
        chk("R3 thermal stays zero", rd_data, 32'h0000_0100);
        chk("R8 status off with duty 0", rd_data[16], 1'b0);
        for (int k = 0; k < 4; k++)
            tick_exp("R8 forced zero duty", 1'b0);
    endtask

    task automatic t_priority();
        do_reset();
        wr(word(2, 1, 6, 1));
        for (int k = 0; k < 8; k++)
            tick_exp($sformatf("R7 forced slot %0d", k), k < 6);
        wr(word(2, 1, 0, 0));
        chk("R7 thermal still 6", rd_data[7:5], 3'd6);
        for (int k = 0; k < 8; k++)
            tick_exp($sformatf("R7 normal slot %0d", k), k < 2);
    endtask

    task automatic t_duty_zero();
        do_reset();
        wr(word(0, 1, 0, 0));
        chk("R8 status with en and duty 0", rd_data[16], 1'b0);
        for (int k = 0; k < 8; k++)
            tick_exp("R8 no stop", 1'b0);
    endtask

    task automatic t_lock_reset();
        do_reset();
        wr(word(0, 0, 4, 0));
        wr(word(0, 0, 1, 0));
        chk("R3 second write ignored", rd_data[7:5], 3'd4);
        do_reset();
        wr(word(0, 0, 2, 0));
        chk("R9 relock after reset", rd_data[7:5], 3'd2);
    endtask

    task automatic t_restart();
        do_reset();
        wr(word(5, 1, 0, 0));
        for (int k = 0; k < 3; k++)
            tick_exp("R5 first slots", 1'b1);
        wr(32'h0);
        chk("R10 status off", rd_data[16], 1'b0);
        chk("R6 stop held until tick", 32'(stop_clk), 32'h1);
        tick_exp("R10 release on tick", 1'b0);
        wr(word(5, 1, 0, 0));
        for (int k = 0; k < 8; k++)
            tick_exp($sformatf("R10 fresh slot %0d", k), k < 5);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_readback();
        t_normal_window();
        t_priority();
        t_duty_zero();
        t_lock_reset();
        t_restart();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule